// File: doc/BRIEF.md
# Programmable Tap Delay Line

This block delays a single-bit sample stream by a programmable number of sample-clock cycles. An 11-bit control word sets the delay. Its low ten bits pick one of 1024 taps of a circular history buffer. Its top bit is a cascade select. That bit is not used inside the block; it is sent out as a complementary pair so that a following stage can extend the total range.

The control word passes through a hold stage. While the hold input is low, the stage is transparent: the word on the pins takes effect on the same clock edge. While the hold input is high, the stage keeps the last value it captured. Two override inputs act on the held select. The force-minimum input has priority and clears it to zero. The force-maximum input sets it to all ones. The value an override writes stays in the hold stage after the override is released, as long as the hold input remains high.

An active-low output enable gates the delayed output to zero. The history buffer keeps shifting while the output is gated, so the output is valid again on the first cycle after it is re-enabled.

Top module: `prog_delay_line`

## Requirements
- R1: Reset drives `sig_out` low, `chain_out` low and `chain_out_n` high, and clears the held control to zero. After reset, with `ctl_hold` high and no override asserted, the delay select is 0.
- R2: With `out_en_n` low, the value of `sig_out` after clock edge k equals the `sig_in` value sampled at edge k−S. S is the effective 10-bit delay select, so the latency is S+1 cycles.
- R3: While `ctl_hold` is low, `ctl_word` is used at the same edge it is sampled. While `ctl_hold` is high, the select and the cascade bit captured at the last edge are reused and the pins are ignored.
- R4: When `force_min` is high, the effective select is 0 and the held select becomes 0, whatever the states of `force_max`, `ctl_hold` and `ctl_word`. The held select stays 0 after `force_min` falls, as long as `ctl_hold` stays high.
- R5: When `force_max` is high and `force_min` is low, the effective select is 1023 and the held select becomes 1023.
- R6: `chain_out` is registered and shows bit 10 of the transparent or held control word. `chain_out_n` is its complement. The overrides do not affect either output.
- R7: When `out_en_n` is high at an edge, `sig_out` is low after that edge.
- R8: The history buffer shifts every cycle, even while the output is gated. On the first edge after `out_en_n` returns low, `sig_out` already shows the delayed sample, including samples taken while the output was gated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Sample stream to be delayed |
| ctl_word | input | 11 | Bits 9:0 delay select, bit 10 cascade select |
| ctl_hold | input | 1 | High holds the control word, low passes it through |
| force_min | input | 1 | Forces the select to zero (highest priority) |
| force_max | input | 1 | Forces the select to all ones |
| out_en_n | input | 1 | Active-low output enable |
| sig_out | output | 1 | Delayed sample stream (registered) |
| chain_out | output | 1 | Cascade select, true polarity |
| chain_out_n | output | 1 | Cascade select, complement |

## Verification
The hardest state to reach from the ports is a long delay at or near 1023 taps. Checking it means every history entry must hold a known value first, and the buffer must not carry any stale contents left over from before reset. The stimulus therefore runs more than 1024 cycles of random samples with the hold stage cleared by reset before any tap comparison is made. It then sets the maximum select, first through the word and later through the override, and keeps it held while the stream keeps changing. A second hard case is a write by an override that must persist in the hold stage. To reach it, the stimulus pulses an override while the hold input is high and then presents a conflicting word, so that only a held value can explain the observed delay.

// File: rtl/pdl_pkg.sv
package pdl_pkg;
  // Which source sets the effective delay select this cycle
  typedef enum logic [1:0] {
    SRC_WORD = 2'd0,
    SRC_MIN  = 2'd1,
    SRC_MAX  = 2'd2
  } sel_src_e;
endpackage

// File: rtl/pdl_ctrl_latch.sv
module pdl_ctrl_latch
  import pdl_pkg::*;
#(
  parameter int SEL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W:0]   ctl_word,
  input  logic             ctl_hold,
  input  logic             force_min,
  input  logic             force_max,
  output logic [SEL_W-1:0] eff_sel,
  output logic             eff_casc
);
  localparam logic [SEL_W-1:0] SEL_MAX_V = '1;

  logic [SEL_W-1:0] held_sel;
  logic             held_casc;
  logic [SEL_W-1:0] word_sel;
  sel_src_e         src;

  // Transparent when ctl_hold is low, otherwise reuse the captured value
  always_comb begin
    word_sel = ctl_hold ? held_sel  : ctl_word[SEL_W-1:0];
    eff_casc = ctl_hold ? held_casc : ctl_word[SEL_W];
    if (force_min)      src = SRC_MIN;
    else if (force_max) src = SRC_MAX;
    else                src = SRC_WORD;
    case (src)
      SRC_MIN: eff_sel = '0;
      SRC_MAX: eff_sel = SEL_MAX_V;
      default: eff_sel = word_sel;
    endcase
  end

  // Overrides write into the held state so they persist after release
  always_ff @(posedge clk) begin
    if (rst) begin
      held_sel  <= '0;
      held_casc <= 1'b0;
    end else begin
      held_sel  <= eff_sel;
      held_casc <= eff_casc;
    end
  end

  a_r4_min_clears: assert property (@(posedge clk) disable iff (rst)
    force_min |=> (held_sel == '0));
  a_r5_max_sets: assert property (@(posedge clk) disable iff (rst)
    (force_max && !force_min) |=> (held_sel == SEL_MAX_V));
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (ctl_hold && !force_min && !force_max) |=> ($stable(held_sel) && $stable(held_casc)));
endmodule

// File: rtl/pdl_tap_chain.sv
module pdl_tap_chain #(
  parameter int SEL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  output logic             tap
);
  localparam int DEPTH  = 1 << SEL_W;
  localparam int ADDR_W = SEL_W;

  logic              hist [DEPTH];
  logic [ADDR_W-1:0] wptr;
  logic [ADDR_W-1:0] rd_addr;

  // Circular write pointer stands in for a shift chain
  always_ff @(posedge clk) begin
    if (rst) wptr <= '0;
    else     wptr <= wptr + 1'b1;
  end

  // No reset on storage so it can map onto RAM
  always_ff @(posedge clk) begin
    hist[wptr] <= din;
  end

  // Tap 0 is the live sample; tap S was written S edges ago
  always_comb begin
    rd_addr = wptr - sel;
    tap     = (sel == '0) ? din : hist[rd_addr];
  end

  a_r8_ptr_advance: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (wptr == ADDR_W'($past(wptr) + 1'b1)));
endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line #(
  parameter int SEL_W = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sig_in,
  input  logic [SEL_W:0] ctl_word,
  input  logic           ctl_hold,
  input  logic           force_min,
  input  logic           force_max,
  input  logic           out_en_n,
  output logic           sig_out,
  output logic           chain_out,
  output logic           chain_out_n
);
  logic [SEL_W-1:0] eff_sel;
  logic             eff_casc;
  logic             tap;

  pdl_ctrl_latch #(.SEL_W(SEL_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ctl_word  (ctl_word),
    .ctl_hold  (ctl_hold),
    .force_min (force_min),
    .force_max (force_max),
    .eff_sel   (eff_sel),
    .eff_casc  (eff_casc)
  );

  pdl_tap_chain #(.SEL_W(SEL_W)) u_taps (
    .clk (clk),
    .rst (rst),
    .din (sig_in),
    .sel (eff_sel),
    .tap (tap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sig_out     <= 1'b0;
      chain_out   <= 1'b0;
      chain_out_n <= 1'b1;
    end else begin
      sig_out     <= out_en_n ? 1'b0 : tap;
      chain_out   <= eff_casc;
      chain_out_n <= ~eff_casc;
    end
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sig_out && !chain_out && chain_out_n));
  a_r7_gate_low: assert property (@(posedge clk) disable iff (rst)
    out_en_n |=> !sig_out);
  a_r6_follow_word: assert property (@(posedge clk) disable iff (rst)
    !ctl_hold |=> (chain_out == $past(ctl_word[SEL_W])));
  a_r6_pair_opposite: assert property (@(posedge clk) disable iff (rst)
    chain_out != chain_out_n);
endmodule

// File: tb/prog_delay_line_tb.sv
`timescale 1ns/1ps
module prog_delay_line_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sig_in = 1'b0;
  logic [10:0] ctl_word = '0;
  logic        ctl_hold = 1'b1;
  logic        force_min = 1'b0;
  logic        force_max = 1'b0;
  logic        out_en_n = 1'b0;
  logic        sig_out, chain_out, chain_out_n;

  int nchk = 0, nfail = 0, cyc = 0;
  bit hist [2048];
  int m_sel = 0;
  bit m_casc = 0;
  bit prev_dis = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prog_delay_line u_dut (
    .clk(clk), .rst(rst), .sig_in(sig_in), .ctl_word(ctl_word),
    .ctl_hold(ctl_hold), .force_min(force_min), .force_max(force_max),
    .out_en_n(out_en_n), .sig_out(sig_out), .chain_out(chain_out),
    .chain_out_n(chain_out_n)
  );

  // Vector: {hold, fmin, fmax, en_n, word[10:0], cycles[7:0]}
  localparam logic [22:0] VEC [13] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 11'd5,    8'd20},
    {1'b0, 1'b0, 1'b0, 1'b0, 11'h425,  8'd20},
    {1'b1, 1'b0, 1'b0, 1'b0, 11'd3,    8'd20},
    {1'b0, 1'b0, 1'b0, 1'b0, 11'h3FF,  8'd30},
    {1'b0, 1'b1, 1'b1, 1'b0, 11'd200,  8'd10},
    {1'b1, 1'b0, 1'b0, 1'b0, 11'h6BC,  8'd10},
    {1'b1, 1'b0, 1'b1, 1'b0, 11'd9,    8'd10},
    {1'b1, 1'b0, 1'b0, 1'b0, 11'd9,    8'd30},
    {1'b0, 1'b0, 1'b0, 1'b1, 11'd12,   8'd15},
    {1'b0, 1'b0, 1'b0, 1'b0, 11'd12,   8'd15},
    {1'b0, 1'b0, 1'b0, 1'b0, 11'd0,    8'd15},
    {1'b1, 1'b1, 1'b0, 1'b1, 11'h7FF,  8'd8},
    {1'b0, 1'b0, 1'b0, 1'b0, 11'h401,  8'd10}
  };

  task automatic chk(bit ok, string tag, int act, int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", tag, cyc, act, expv);
    end
  endtask

  // One clock: model the edge, then compare at the following falling edge
  task automatic step(bit do_chk, string tag_ovr);
    int  srcs, eff;
    bit  srcc, e_out, dis;
    string tag;
    @(posedge clk);
    srcs = ctl_hold ? m_sel : int'(ctl_word[9:0]);
    srcc = ctl_hold ? m_casc : ctl_word[10];
    eff  = force_min ? 0 : (force_max ? 1023 : srcs);
    hist[cyc % 2048] = sig_in;
    e_out = out_en_n ? 1'b0 : hist[(cyc - eff + 2048) % 2048];
    dis = out_en_n;
    if (out_en_n)       tag = "R7";
    else if (prev_dis)  tag = "R8";
    else if (force_min) tag = "R4";
    else if (force_max) tag = "R5";
    else if (ctl_hold)  tag = "R3";
    else                tag = "R2";
    if (tag_ovr != "") tag = tag_ovr;
    m_sel  = eff;
    m_casc = srcc;
    prev_dis = dis;
    cyc++;
    @(negedge clk);
    if (do_chk) begin
      chk(sig_out === e_out, tag, int'(sig_out), int'(e_out));
      chk(chain_out === srcc && chain_out_n === !srcc, "R6",
          int'({chain_out, chain_out_n}), int'({srcc, !srcc}));
    end
    sig_in = 1'($urandom);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(sig_out === 1'b0, "R1", int'(sig_out), 0);
    chk(chain_out === 1'b0 && chain_out_n === 1'b1, "R1",
        int'({chain_out, chain_out_n}), 1);
    rst = 1'b0;
    // Fill history with hold high: reset-cleared select gives delay 0 (R1)
    ctl_word = 11'h2AA;
    repeat (1040) step(cyc >= 1024, "R1");
    // Table walk
    foreach (VEC[i]) begin
      ctl_hold  = VEC[i][22];
      force_min = VEC[i][21];
      force_max = VEC[i][20];
      out_en_n  = VEC[i][19];
      ctl_word  = VEC[i][18:8];
      repeat (int'(VEC[i][7:0])) step(1'b1, "");
    end
    // R4 directed: min override wins over max and persists in hold
    ctl_hold = 1'b1; force_max = 1'b1; force_min = 1'b1; ctl_word = 11'd77;
    step(1'b1, "R4");
    force_max = 1'b0; force_min = 1'b0; ctl_word = 11'd600;
    repeat (12) step(1'b1, "R4");
    // R5 directed: max override persists in hold
    force_max = 1'b1;
    step(1'b1, "R5");
    force_max = 1'b0; ctl_word = 11'd4;
    repeat (12) step(1'b1, "R5");
    // R3 directed: hold ignores word and cascade bit changes
    ctl_hold = 1'b0; ctl_word = 11'h408;
    step(1'b1, "R3");
    ctl_hold = 1'b1; ctl_word = 11'd1;
    repeat (10) step(1'b1, "R3");
    // R7 then R8: gate during a long delay, history keeps moving
    ctl_hold = 1'b0; ctl_word = 11'd40; out_en_n = 1'b1;
    repeat (25) step(1'b1, "R7");
    out_en_n = 1'b0;
    step(1'b1, "R8");
    repeat (10) step(1'b1, "R2");
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule